// File: doc/BRIEF.md
# Dual-Queue Conversion Scheduler

This block shares one converter between two command queues. Each queue walks a list of command words held in a shared command table. It starts at a base address that is supplied per queue. It sends one conversion request at a time over a start/done handshake. A queue is armed by an enable and a two-bit mode. It is started by a one-cycle trigger pulse. Queue 1 always has priority. A queue 1 trigger that arrives while queue 2 holds the converter cancels the queue 2 request at once. Queue 2 then waits in a suspended state and later retries the same command.

Each command word carries a channel number, a pause flag and an end-of-list flag. When a command with the pause flag completes, its queue stops until its next trigger. When the end-of-list flag is reached, the queue either returns to idle or restarts from its base, depending on the mode. The state of both queues is reported as a single 4-bit status code.

Top module: `dual_queue_sched`

## Requirements
- R1: After reset both queues are idle, status reads 0000, and conv_start and conv_abort are low.
- R2: A queue whose enable is low or whose mode has bit 1 set (modes 10 and 11 are reserved) is idle and ignores its trigger. If such a queue owns the conversion in flight, conv_abort pulses in that cycle.
- R3: A trigger to an idle queue with a valid mode makes it active on the next clock, starting at its base address. Commands are issued in address order. conv_chan equals command bits [CHW-1:0]. A new conv_start waits for the conv_done of the previous request.
- R4: When a command whose end flag (bit CHW+1) is set completes, the queue goes idle in mode 00. In mode 01 it restarts at its base and stays active.
- R5: When a command whose pause flag (bit CHW) is set completes, its queue is paused and issues nothing. Its next trigger resumes it at the following command.
- R6: At most one queue is active. A queue 2 trigger that arrives while queue 1 is active (or is being triggered) leaves queue 2 trigger-pending. Queue 2 becomes active one clock after queue 1 is seen not active.
- R7: A queue 1 trigger accepted while queue 2 is active suspends queue 2. If a queue 2 request is in flight, conv_abort is high in that same cycle and a conv_done in that cycle is ignored.
- R8: A suspended queue 2 becomes active on the clock at which queue 1 leaves the active state. It restarts at the aborted command.
- R9: While queue 1 is paused or idle, queue 2 is served normally.
- R10: The status codes are as follows. Queue 1 idle with queue 2 idle, active, paused or pending: 0000, 0001, 0010, 0011. Queue 1 paused with queue 2 idle, active, paused or pending: 0100, 0101, 0110, 1000. Queue 1 active with queue 2 idle, paused, suspended or pending: 1001, 1010, 1011, 1100. Codes 0111 and 1101 to 1111 are never produced in normal operation.
- R11: A trigger to a queue that is already active, suspended or pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q1_en | input | 1 | Queue 1 enable |
| q1_mode | input | 2 | Queue 1 mode: 00 single pass, 01 repeating, 1x reserved |
| q1_trig | input | 1 | Queue 1 trigger pulse |
| q1_base | input | AW | Queue 1 first command address |
| q2_en | input | 1 | Queue 2 enable |
| q2_mode | input | 2 | Queue 2 mode, same coding as queue 1 |
| q2_trig | input | 1 | Queue 2 trigger pulse |
| q2_base | input | AW | Queue 2 first command address |
| cmd_addr | output | AW | Command table read address |
| cmd_word | input | CHW+2 | Command word at cmd_addr, same cycle |
| conv_start | output | 1 | Request a conversion on conv_chan |
| conv_chan | output | CHW | Channel of the requested conversion |
| conv_done | input | 1 | Converter finished the request in flight |
| conv_abort | output | 1 | Cancel the request in flight |
| status | output | 4 | Combined queue status code |

## Verification
On every cycle the assertions check the following: no two queues are active together; a suspended queue 2 implies an active queue 1; no reserved status code appears; a paused queue issues nothing; a preempted queue 2 keeps its command pointer. Only the bench's scenarios can show that commands go out in the right order with the right channels, that a suspended queue retries exactly the aborted channel, and that the pause, end-of-list and repeat endings behave as required. They also show the one-cycle pending window that produces code 1000, and that disabled or reserved-mode queues ignore their triggers.

// File: rtl/dual_queue_sched.sv
module dual_queue_sched #(
  parameter int CHW = 3,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           q1_en,
  input  logic [1:0]     q1_mode,
  input  logic           q1_trig,
  input  logic [AW-1:0]  q1_base,
  input  logic           q2_en,
  input  logic [1:0]     q2_mode,
  input  logic           q2_trig,
  input  logic [AW-1:0]  q2_base,
  output logic [AW-1:0]  cmd_addr,
  input  logic [CHW+1:0] cmd_word,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  output logic           conv_abort,
  output logic [3:0]     status
);
  localparam int PBIT = CHW;
  localparam int EBIT = CHW + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_ACT, ST_PAUSE, ST_SUSP, ST_PEND} qstate_t;

  qstate_t s1, s2, s1_n, s2_n;
  logic [AW-1:0] p1, p2, p1_n, p2_n;
  logic busy, own2, lat_pause, lat_end;
  logic v1, v2, go1, done_ok, fin1, fin2, iss1, iss2;

  assign v1 = q1_en && !q1_mode[1];
  assign v2 = q2_en && !q2_mode[1];
  assign go1 = v1 && q1_trig && (s1 != ST_ACT);
  assign conv_abort = busy && (own2 ? (go1 || !v2) : !v1);
  assign done_ok = busy && conv_done && !conv_abort;
  assign fin1 = done_ok && !own2;
  assign fin2 = done_ok && own2;
  assign iss1 = !busy && v1 && (s1 == ST_ACT);
  assign iss2 = !busy && v2 && (s2 == ST_ACT) && !go1 && !iss1;

  assign cmd_addr   = (s1 == ST_ACT) ? p1 : p2;
  assign conv_start = iss1 || iss2;
  assign conv_chan  = cmd_word[CHW-1:0];

  always_comb begin
    s1_n = s1;
    p1_n = p1;
    if (!v1) s1_n = ST_IDLE;
    else if (go1) begin
      s1_n = ST_ACT;
      if (s1 == ST_IDLE) p1_n = q1_base;
    end else if (fin1) begin
      p1_n = lat_end ? q1_base : p1 + 1'b1;
      if (lat_end && !q1_mode[0]) s1_n = ST_IDLE;
      else if (lat_pause)         s1_n = ST_PAUSE;
      else                        s1_n = ST_ACT;
    end
  end

  always_comb begin
    s2_n = s2;
    p2_n = p2;
    if (!v2) s2_n = ST_IDLE;
    else begin
      case (s2)
        ST_IDLE, ST_PAUSE: if (q2_trig) begin
          s2_n = ((s1 == ST_ACT) || go1) ? ST_PEND : ST_ACT;
          if (s2 == ST_IDLE) p2_n = q2_base;
        end
        ST_ACT: if (go1) s2_n = ST_SUSP;
          else if (fin2) begin
            p2_n = lat_end ? q2_base : p2 + 1'b1;
            if (lat_end && !q2_mode[0]) s2_n = ST_IDLE;
            else if (lat_pause)         s2_n = ST_PAUSE;
            else                        s2_n = ST_ACT;
          end
        ST_SUSP: if (s1_n != ST_ACT) s2_n = ST_ACT;
        ST_PEND: if ((s1 != ST_ACT) && !go1) s2_n = ST_ACT;
        default: s2_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= ST_IDLE;
      s2 <= ST_IDLE;
      p1 <= '0;
      p2 <= '0;
      busy <= 1'b0;
      own2 <= 1'b0;
      lat_pause <= 1'b0;
      lat_end <= 1'b0;
    end else begin
      s1 <= s1_n;
      s2 <= s2_n;
      p1 <= p1_n;
      p2 <= p2_n;
      if (conv_abort || done_ok) busy <= 1'b0;
      else if (conv_start) begin
        busy <= 1'b1;
        own2 <= iss2;
        lat_pause <= cmd_word[PBIT];
        lat_end <= cmd_word[EBIT];
      end
    end
  end

  always_comb begin
    status = 4'b1111;
    case (s1)
      ST_IDLE:
        case (s2)
          ST_IDLE:  status = 4'b0000;
          ST_ACT:   status = 4'b0001;
          ST_PAUSE: status = 4'b0010;
          ST_PEND:  status = 4'b0011;
          default:  status = 4'b1111;
        endcase
      ST_PAUSE:
        case (s2)
          ST_IDLE:  status = 4'b0100;
          ST_ACT:   status = 4'b0101;
          ST_PAUSE: status = 4'b0110;
          ST_PEND:  status = 4'b1000;
          default:  status = 4'b1111;
        endcase
      ST_ACT:
        case (s2)
          ST_IDLE:  status = 4'b1001;
          ST_PAUSE: status = 4'b1010;
          ST_SUSP:  status = 4'b1011;
          ST_PEND:  status = 4'b1100;
          default:  status = 4'b1111;
        endcase
      default: status = 4'b1111;
    endcase
  end

  a_r6_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    !((s1 == ST_ACT) && (s2 == ST_ACT)));

  a_r8_susp_needs_q1: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 == ST_SUSP) |-> (s1 == ST_ACT));

  a_r7_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    ((s2 == ST_ACT) && v2 && v1 && q1_trig && (s1 != ST_ACT)) |=> (s2 == ST_SUSP));

  a_r8_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_abort && own2) |=> (p2 == $past(p2)));

  a_r10_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 4'b0111) && (status < 4'd13));

  a_r5_paused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((s1 == ST_PAUSE) && (s2 != ST_ACT)) |-> !conv_start);

  a_r2_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !q1_en |=> (s1 == ST_IDLE));
endmodule

// File: tb/dual_queue_sched_test.sv
module dual_queue_sched_test;
  localparam int CHW = 3;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q1_en, q1_trig, q2_en, q2_trig, conv_done;
  logic [1:0] q1_mode, q2_mode;
  logic [AW-1:0] q1_base, q2_base, cmd_addr;
  logic [CHW+1:0] cmd_word;
  logic conv_start, conv_abort;
  logic [CHW-1:0] conv_chan;
  logic [3:0] status;
  logic [CHW+1:0] cmem [16];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  assign cmd_word = cmem[cmd_addr];

  dual_queue_sched #(.CHW(CHW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .q1_en(q1_en), .q1_mode(q1_mode), .q1_trig(q1_trig), .q1_base(q1_base),
    .q2_en(q2_en), .q2_mode(q2_mode), .q2_trig(q2_trig), .q2_base(q2_base),
    .cmd_addr(cmd_addr), .cmd_word(cmd_word),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_abort(conv_abort), .status(status)
  );

  // {q1_trig,q2_trig,done, status, start, chan, abort}
  localparam logic [11:0] VEC [28] = '{
    12'b000_0000_0_000_0, 12'b010_0000_0_000_0, 12'b000_0001_1_100_0, 12'b000_0001_0_000_0,
    12'b001_0001_0_000_0, 12'b000_0001_1_101_0, 12'b100_0001_0_000_1, 12'b000_1011_1_001_0,
    12'b001_1011_0_000_0, 12'b000_1011_1_010_0, 12'b001_1011_0_000_0, 12'b000_0101_1_101_0,
    12'b001_0101_0_000_0, 12'b000_0101_1_110_0, 12'b001_0101_0_000_0, 12'b000_0100_0_000_0,
    12'b100_0100_0_000_0, 12'b010_1001_1_011_0, 12'b000_1100_0_000_0, 12'b001_1100_0_000_0,
    12'b000_0011_0_000_0, 12'b000_0001_1_100_0, 12'b001_0001_0_000_0, 12'b010_0001_1_101_0,
    12'b001_0001_0_000_0, 12'b000_0001_1_110_0, 12'b001_0001_0_000_0, 12'b000_0000_0_000_0
  };

  function automatic string vtag(int k);
    if (k == 0) return "R1 reset idle";
    if (k <= 5) return "R3 ordered issue";
    if (k <= 7) return "R7 preempt abort";
    if (k <= 11) return "R8 resume aborted command";
    if (k <= 15) return "R9 serve q2 while q1 paused";
    if (k == 16) return "R5 resume after pause";
    if (k <= 21) return "R6 pending then active";
    if (k == 22) return "R10 code table";
    if (k <= 26) return "R11 trigger to active queue";
    return "R4 end of list to idle";
  endfunction

  task automatic load_table();
    for (int i = 0; i < 16; i++) cmem[i] = '0;
    cmem[0] = 5'b00_001; cmem[1] = 5'b01_010; cmem[2] = 5'b10_011;
    cmem[8] = 5'b00_100; cmem[9] = 5'b00_101; cmem[10] = 5'b10_110;
  endtask

  task automatic do_reset(input logic [1:0] m1, input logic [1:0] m2);
    @(negedge clk);
    rst_n = 1'b0;
    q1_en = 1'b1; q2_en = 1'b1; q1_mode = m1; q2_mode = m2;
    q1_trig = 1'b0; q2_trig = 1'b0; conv_done = 1'b0;
    q1_base = 4'd0; q2_base = 4'd8;
    load_table();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic e1, input logic t1, input logic t2, input logic dn,
                      input logic [3:0] es, input logic est, input logic [2:0] ech,
                      input logic eab, input string tag);
    @(negedge clk);
    q1_en = e1; q1_trig = t1; q2_trig = t2; conv_done = dn;
    #1;
    checks++;
    if (status !== es || conv_start !== est || (est && conv_chan !== ech) || conv_abort !== eab) begin
      errors++;
      $display("FAIL %s: status=%b start=%b chan=%0d abort=%b expected status=%b start=%b chan=%0d abort=%b",
               tag, status, conv_start, conv_chan, conv_abort, es, est, ech, eab);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    q1_en = 1'b1; q2_en = 1'b1; q1_mode = 2'b00; q2_mode = 2'b00;
    q1_trig = 1'b0; q2_trig = 1'b0; conv_done = 1'b0;
    q1_base = 4'd0; q2_base = 4'd8;
    load_table();
    #1;
    checks++;
    if (status !== 4'b0000 || conv_start !== 1'b0 || conv_abort !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: status=%b start=%b abort=%b expected 0000 0 0", status, conv_start, conv_abort);
    end

    do_reset(2'b00, 2'b00);
    for (int k = 0; k < 28; k++)
      step(1'b1, VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][8:5], VEC[k][4], VEC[k][3:1], VEC[k][0], vtag(k));

    // queue 2 with a pausing command: codes 0010, 1010, 1100, 1000, 0110
    do_reset(2'b00, 2'b00);
    cmem[9] = 5'b01_101;
    step(1, 0, 1, 0, 4'b0000, 0, 0, 0, "R3 q2 trigger");
    step(1, 0, 0, 0, 4'b0001, 1, 4, 0, "R3 q2 first command");
    step(1, 0, 0, 1, 4'b0001, 0, 0, 0, "R3 done");
    step(1, 0, 0, 0, 4'b0001, 1, 5, 0, "R3 second command");
    step(1, 0, 0, 1, 4'b0001, 0, 0, 0, "R5 pause command done");
    step(1, 0, 0, 0, 4'b0010, 0, 0, 0, "R5 q2 paused code 0010");
    step(1, 1, 0, 0, 4'b0010, 0, 0, 0, "R10 q1 trigger");
    step(1, 0, 0, 0, 4'b1010, 1, 1, 0, "R10 code 1010");
    step(1, 0, 0, 1, 4'b1010, 0, 0, 0, "R3 q1 done");
    step(1, 0, 1, 0, 4'b1010, 1, 2, 0, "R6 q2 trigger during q1");
    step(1, 0, 0, 1, 4'b1100, 0, 0, 0, "R6 code 1100");
    step(1, 0, 0, 0, 4'b1000, 0, 0, 0, "R6 code 1000 pending window");
    step(1, 0, 0, 0, 4'b0101, 1, 6, 0, "R5 q2 resumes after pause");
    step(1, 0, 0, 1, 4'b0101, 0, 0, 0, "R4 end of list");
    step(1, 0, 0, 0, 4'b0100, 0, 0, 0, "R4 q2 idle code 0100");
    step(1, 0, 1, 0, 4'b0100, 0, 0, 0, "R9 q2 trigger while q1 paused");
    step(1, 0, 0, 0, 4'b0101, 1, 4, 0, "R9 q2 restarts at base");
    step(1, 0, 0, 1, 4'b0101, 0, 0, 0, "R9 done");
    step(1, 0, 0, 0, 4'b0101, 1, 5, 0, "R9 next");
    step(1, 0, 0, 1, 4'b0101, 0, 0, 0, "R5 pause done");
    step(1, 0, 0, 0, 4'b0110, 0, 0, 0, "R10 code 0110");

    // repeating mode, disable abort, reserved mode
    do_reset(2'b01, 2'b00);
    cmem[1] = 5'b00_010;
    step(1, 1, 0, 0, 4'b0000, 0, 0, 0, "R3 q1 trigger");
    step(1, 0, 0, 0, 4'b1001, 1, 1, 0, "R3 q1 first");
    step(1, 0, 0, 1, 4'b1001, 0, 0, 0, "R3 done");
    step(1, 1, 0, 0, 4'b1001, 1, 2, 0, "R11 q1 trigger while active");
    step(1, 0, 0, 1, 4'b1001, 0, 0, 0, "R11 done");
    step(1, 0, 0, 0, 4'b1001, 1, 3, 0, "R11 order kept");
    step(1, 0, 0, 1, 4'b1001, 0, 0, 0, "R4 end in repeating mode");
    step(1, 0, 0, 0, 4'b1001, 1, 1, 0, "R4 wraps to base");
    step(0, 0, 0, 0, 4'b1001, 0, 0, 1, "R2 disable aborts");
    step(0, 0, 0, 0, 4'b0000, 0, 0, 0, "R2 disabled idle");
    step(0, 1, 0, 0, 4'b0000, 0, 0, 0, "R2 trigger while disabled");
    step(0, 0, 0, 0, 4'b0000, 0, 0, 0, "R2 still idle");
    do_reset(2'b10, 2'b00);
    step(1, 1, 0, 0, 4'b0000, 0, 0, 0, "R2 reserved mode trigger");
    step(1, 0, 0, 0, 4'b0000, 0, 0, 0, "R2 reserved mode idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule